// File: doc/BRIEF.md
# Two-Half Clock-Gated Row Selector Ring

This block walks a single active select line across `N` rows, one row per advance request, and returns to row 0 after row `N-1`. A small buffer or RAM uses the select vector to pick the row it accesses. The ring is first loaded with one hot bit on row 0. Until that load happens the ring holds no hot bit, does nothing, and reports an error.

To save clock power the ring is cut into a lower half (rows `0..N/2-1`) and an upper half (rows `N/2..N-1`). Each half has its own clock-enable controller, a set/clear enable flop. Only the half that holds the hot bit is clocked. The other half keeps its stages frozen at zero. When the hot bit crosses from one half to the other, the receiving half is enabled for that edge and the sending half is turned off by the same edge. The enables are modelled as synchronous clock-enable terms, so the block suits an FPGA or any flow that maps clock enables onto gating cells.

A sticky health flag reports an illegal state. The flag rises if the ring holds a number of hot bits other than one, or if both half enables hold the same value.

Top module: `ring_row_selector`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `row_sel` all zero, `en_lo`=0, `en_hi`=0 and `err`=0.
- R2: A rising edge with `load` high (and `rst` low) sets `row_sel` to bit 0 only, with `en_lo`=1, `en_hi`=0 and `err`=0. `load` takes priority over `advance`.
- R3: On an edge with `advance` high and a single hot bit present, the bit moves from row i to row i+1, and from row `N-1` back to row 0. The pattern therefore repeats every `N` advances.
- R4: On an edge with `advance` low and `load` low, `row_sel`, `en_lo` and `en_hi` keep their values.
- R5: An advance while the hot bit sits on row `N/2-1` gives `en_hi`=1 and `en_lo`=0 after that edge.
- R6: An advance while the hot bit sits on row `N-1` gives `en_lo`=1 and `en_hi`=0 after that edge.
- R7: After a load, exactly one of `en_lo`/`en_hi` is high. `en_lo` is high exactly when the hot bit lies in rows `0..N/2-1`.
- R8: The half that is not enabled keeps all its `row_sel` bits unchanged (zero), except on the handover edge that brings the hot bit into it.
- R9: `err` rises one edge after any edge without `load`/`rst` at which `row_sel` does not hold exactly one 1, or `en_lo` equals `en_hi`. It then stays high until `load` or `rst`.
- R10: With no hot bit loaded, `advance` leaves `row_sel` all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Preload one hot bit on row 0 and enable the lower half |
| advance | input | 1 | Move the hot bit by one row |
| row_sel | output | N | Registered one-hot row select |
| en_lo | output | 1 | Clock enable state of the lower half |
| en_hi | output | 1 | Clock enable state of the upper half |
| err | output | 1 | Sticky illegal-state flag |

## Verification
Every output is a register, so `row_sel`, `en_lo` and `en_hi` reflect a `load`, `advance` or `rst` one edge after it. `err` reflects the state that existed before that edge, so it trails an illegal state by exactly one edge. The bench drives inputs on the falling edge and steps a behavioural model (a hot-bit position integer, two enable bits and an error bit) on each rising edge. It compares all four outputs on the next falling edge. Phases cover the unloaded ring, full rotations through both handovers, irregular advance gaps, long holds, a reload mid-rotation and a reset mid-rotation.

// File: rtl/ring_sel_pkg.sv
package ring_sel_pkg;
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;
  localparam int MIN_STAGES = 4;
endpackage

// File: rtl/ring_half.sv
module ring_half #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_pat,
  input  logic         ce,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_pat;
    else if (ce)   q <= (q << 1) | W'(din);
  end
endmodule

// File: rtl/half_gate_ctrl.sv
module half_gate_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic load_val,
  input  logic set_en,
  input  logic clr_en,
  output logic en
);
  // set/clear enable flop; set wins if both ever fire together
  always_ff @(posedge clk) begin
    if (rst)         en <= 1'b0;
    else if (load)   en <= load_val;
    else if (set_en) en <= 1'b1;
    else if (clr_en) en <= 1'b0;
  end
endmodule

// File: rtl/ring_health.sv
module ring_health #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] sel,
  input  logic         en_a,
  input  logic         en_b,
  output logic         err
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};
  logic none_hot, multi_hot, bad;

  always_comb begin
    none_hot  = (sel == '0);
    multi_hot = ((sel & (sel - ONE)) != '0);
    bad       = none_hot | multi_hot | (en_a == en_b);
  end

  always_ff @(posedge clk) begin
    if (rst || load) err <= 1'b0;
    else             err <= err | bad;
  end
endmodule

// File: rtl/ring_row_selector.sv
module ring_row_selector #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         advance,
  output logic [N-1:0] row_sel,
  output logic         en_lo,
  output logic         en_hi,
  output logic         err
);
  import ring_sel_pkg::*;
  localparam int H = N / 2;

  initial begin
    if (N < MIN_STAGES || (N % 2) != 0)
      $error("ring_row_selector: N must be even and at least %0d", MIN_STAGES);
  end

  logic [H-1:0] q_half [2];
  logic [1:0]   en, set_en, clr_en, ce, din;

  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam int OTHER = 1 - g;
    localparam logic [H-1:0] LOAD_PAT =
      (g == int'(HALF_LO)) ? {{(H-1){1'b0}}, 1'b1} : '0;

    assign din[g]    = q_half[OTHER][H-1];
    assign set_en[g] = advance & q_half[OTHER][H-1];
    assign clr_en[g] = advance & q_half[g][H-1];
    assign ce[g]     = advance & (en[g] | set_en[g]);

    ring_half #(.W(H)) u_half (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .load_pat(LOAD_PAT),
      .ce      (ce[g]),
      .din     (din[g]),
      .q       (q_half[g])
    );

    half_gate_ctrl u_gate (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .load_val(g == int'(HALF_LO)),
      .set_en  (set_en[g]),
      .clr_en  (clr_en[g]),
      .en      (en[g])
    );
  end

  assign row_sel = {q_half[1], q_half[0]};
  assign en_lo   = en[0];
  assign en_hi   = en[1];

  ring_health #(.N(N)) u_health (
    .clk (clk),
    .rst (rst),
    .load(load),
    .sel (row_sel),
    .en_a(en[0]),
    .en_b(en[1]),
    .err (err)
  );
endmodule

// File: rtl/ring_row_selector_chk.sv
module ring_row_selector_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic         advance,
  input logic [N-1:0] row_sel,
  input logic         en_lo,
  input logic         en_hi,
  input logic         err
);
  localparam int H = N / 2;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  p_load_state_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (row_sel == ONE) && en_lo && !en_hi && !err);

  p_rotate_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && $countones(row_sel) == 1)
      |=> row_sel == {$past(row_sel[N-2:0]), $past(row_sel[N-1])});

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!advance && !load) |=> $stable(row_sel) && $stable(en_lo) && $stable(en_hi));

  p_to_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && row_sel[H-1]) |=> en_hi && !en_lo);

  p_to_lower_r6: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && row_sel[N-1]) |=> en_lo && !en_hi);

  p_enable_tracks_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(row_sel) == 1) |-> (en_lo != en_hi) && (en_lo == |row_sel[H-1:0]));

  p_never_both_r7: assert property (@(posedge clk) disable iff (rst)
    !(en_lo && en_hi));

  p_upper_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !en_hi && !(advance && row_sel[H-1])) |=> $stable(row_sel[N-1:H]));

  p_err_rise_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && ($countones(row_sel) != 1 || en_lo == en_hi)) |=> err);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (err && !load) |=> err);

  p_unloaded_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (row_sel == '0 && !load) |=> row_sel == '0);
endmodule

bind ring_row_selector ring_row_selector_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .load(load), .advance(advance),
  .row_sel(row_sel), .en_lo(en_lo), .en_hi(en_hi), .err(err)
);

// File: tb/ring_row_selector_test.sv
`timescale 1ns/1ps
module ring_row_selector_test;
  localparam int N = 8;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rst = 1'b1, load = 1'b0, advance = 1'b0;
  logic [N-1:0] row_sel;
  logic en_lo, en_hi, err;

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R1";

  // behavioural reference: hot position (-1 = none), enables, error
  int m_pos = -1;
  bit m_lo = 0, m_hi = 0, m_err = 0;

  always #2.5 clk = ~clk;

  ring_row_selector #(.N(N)) uut (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .row_sel(row_sel), .en_lo(en_lo), .en_hi(en_hi), .err(err)
  );

  always @(posedge clk) begin
    bit bad;
    if (rst) begin
      m_pos = -1; m_lo = 0; m_hi = 0; m_err = 0;
    end else if (load) begin
      m_pos = 0; m_lo = 1; m_hi = 0; m_err = 0;
    end else begin
      bad = (m_pos < 0) || (m_lo == m_hi);
      m_err = m_err | bad;
      if (advance && m_pos >= 0) begin
        if (m_pos == H-1)      begin m_lo = 0; m_hi = 1; end
        else if (m_pos == N-1) begin m_lo = 1; m_hi = 0; end
        m_pos = (m_pos + 1) % N;
      end
    end
  end

  function automatic logic [N+2:0] expected();
    logic [N-1:0] s;
    s = (m_pos < 0) ? '0 : (N'(1) << m_pos);
    return {s, m_lo, m_hi, m_err};
  endfunction

  task automatic check_now();
    logic [N+2:0] act, exp;
    act = {row_sel, en_lo, en_hi, err};
    exp = expected();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {row_sel,en_lo,en_hi,err} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  task automatic step(input bit a, input bit l, input bit r);
    advance = a; load = l; rst = r;
    @(negedge clk);
    check_now();
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    req = "R1";
    step(1, 0, 1);
    step(0, 0, 1);
    // R10 / R9: unloaded ring ignores advance, error rises and sticks
    req = "R10";
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    req = "R9";
    for (int i = 0; i < 2; i++) step(0, 0, 0);
    // R2: load beats advance and clears err
    req = "R2";
    step(1, 1, 0);
    // R3 R5 R6 R7: two and a half full rotations
    req = "R3";
    for (int i = 0; i < 2*N + H; i++) begin
      if (m_pos == H-1)      req = "R5";
      else if (m_pos == N-1) req = "R6";
      else                   req = (i % 2) ? "R7" : "R3";
      step(1, 0, 0);
    end
    // R4 R8: irregular advance gaps keep idle half frozen
    req = "R8";
    for (int i = 0; i < 40; i++) begin
      req = ((i % 3) == 0) ? "R4" : "R8";
      step(((i % 3) != 0) && ((i % 7) != 5), 0, 0);
    end
    req = "R4";
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    // R2: reload in the middle of a rotation
    req = "R2";
    step(0, 1, 0);
    req = "R3";
    for (int i = 0; i < N + 2; i++) step(1, 0, 0);
    // R1: reset in mid-rotation, then R9 again before reload
    req = "R1";
    step(1, 0, 1);
    req = "R9";
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    req = "R2";
    step(0, 1, 0);
    req = "R7";
    for (int i = 0; i < N; i++) step(1, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule